// File: doc/BRIEF.md
# Core Register Window Address Guard

This block sits between the core's load/store path and the bus that reaches the core's memory-mapped control registers. Every request whose address lies in the 1 MB register window (address bits 31:20 equal to 0xFFE) is checked against the implemented register map. The check has three levels. Bits 19:16 must be zero. The peripheral index in bits 15:12 must name one of the implemented peripherals. The 12-bit offset in bits 11:0 must be word aligned and no larger than the last implemented offset of that peripheral. Requests outside the window are not checked and pass through.

A legal request goes to the downstream register bus unchanged in the same cycle. An illegal request is not forwarded, so a store has no effect and a load returns zero. In the same cycle the block raises a protection-exception pulse carrying cause 0x2E (a protection violation in supervisor context). On the next clock edge the block captures the offending address, the program counter of the faulting instruction and the cause. These captured values stay readable until the next fault. Software may also load the fault-address register directly, for example to clear it before a test.

Top module: `mmr_addr_guard`

## Requirements
- R1: A request whose address bits 31:20 differ from 0xFFE never raises the exception and is forwarded downstream.
- R2: A window request with any nonzero bit among address bits 19:16 is illegal.
- R3: A window request whose peripheral index (bits 15:12) is 9 or more is illegal under the default of 9 peripherals.
- R4: The last implemented offset is 0x404 for peripherals 0 and 1, 0x110 for peripheral 2, 0x00C for peripherals 3 and 5, 0x004 for peripheral 4, 0x100 for peripheral 6, 0x200 for peripheral 7 and 0x104 for peripheral 8. An aligned offset at or below the limit is legal, and any offset above it is illegal.
- R5: A window offset whose bits 1:0 are not both zero is illegal.
- R6: An illegal valid request drives `exc_valid` high and `exc_cause` to 0x2E in the same cycle and keeps `dn_valid` low, so the store is blocked. Without a valid request, `exc_valid` stays low.
- R7: An illegal read returns zero on `rsp_rdata`. Any other read returns `dn_rdata`.
- R8: On the clock edge after a fault, `fault_addr`, `fault_pc` and `fault_cause` hold the request address, the request PC and 0x2E. They keep these values while no fault and no software write occur.
- R9: `sw_faddr_we` loads `sw_faddr_data` into `fault_addr` on the next edge. If a fault happens in the same cycle, the fault capture wins.
- R10: While reset is asserted, the captured registers read zero.
- R11: A legal request appears on `dn_addr`, `dn_write` and `dn_wdata` unchanged, with `dn_valid` equal to `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core access request valid |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| req_pc | input | 32 | PC of the issuing instruction |
| rsp_rdata | output | 32 | Load data returned to the core |
| dn_valid | output | 1 | Downstream request valid |
| dn_addr | output | 32 | Downstream address |
| dn_write | output | 1 | Downstream store flag |
| dn_wdata | output | 32 | Downstream store data |
| dn_rdata | input | 32 | Downstream load data |
| exc_valid | output | 1 | Protection-exception pulse |
| exc_cause | output | 6 | Exception cause (0x2E when raised, else 0) |
| sw_faddr_we | input | 1 | Software write strobe for the fault-address register |
| sw_faddr_data | input | 32 | Software write data |
| fault_addr | output | 32 | Captured fault address |
| fault_pc | output | 32 | Captured PC of the faulting instruction |
| fault_cause | output | 6 | Captured cause |

## Verification
The assertions assume that the request fields are stable and meaningful only while `req_valid` is high. They also assume that `dn_rdata` belongs to the current request within the same cycle. The bench therefore holds every request for a whole clock, from one falling edge to the next, and keeps `dn_rdata` at a fixed marker pattern, so a zero response can only come from the guard. The hold property for the captured registers assumes that software writes come only through `sw_faddr_we`. The bench raises that strobe only in its dedicated directed steps.

// File: rtl/mmr_guard_pkg.sv
package mmr_guard_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned CAUSE_W = 6;
  localparam logic [11:0] WINDOW_TAG = 12'hFFE;
  localparam logic [CAUSE_W-1:0] CAUSE_PROT_SUPV = 6'h2E;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = '0;
endpackage

// File: rtl/mmr_window_decode.sv
module mmr_window_decode
  import mmr_guard_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 9,
  parameter logic [NUM_PERIPH-1:0][11:0] OFF_LIMIT = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic              legal
);
  localparam int unsigned IDX_W = 4;

  logic [IDX_W-1:0]      pidx;
  logic [11:0]           offset;
  logic                  high_clear;
  logic                  idx_ok;
  logic                  aligned;
  logic [NUM_PERIPH-1:0] off_hit;

  assign pidx       = addr[15:12];
  assign offset     = addr[11:0];
  assign in_window  = (addr[31:20] == WINDOW_TAG);
  assign high_clear = (addr[19:16] == 4'h0);
  assign idx_ok     = (int'(pidx) < int'(NUM_PERIPH));
  assign aligned    = (offset[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_limit
    assign off_hit[g] = (int'(pidx) == g) && (offset <= OFF_LIMIT[g]);
  end

  assign legal = high_clear && idx_ok && aligned && (|off_hit);
endmodule

// File: rtl/mmr_fault_capture.sv
module mmr_fault_capture
  import mmr_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_en,
  input  logic [ADDR_W-1:0]  fault_addr_in,
  input  logic [ADDR_W-1:0]  fault_pc_in,
  input  logic               sw_we,
  input  logic [ADDR_W-1:0]  sw_data,
  output logic [ADDR_W-1:0]  faddr_q,
  output logic [ADDR_W-1:0]  fpc_q,
  output logic [CAUSE_W-1:0] cause_q
);
  logic [ADDR_W-1:0]  faddr_d;
  logic [ADDR_W-1:0]  fpc_d;
  logic [CAUSE_W-1:0] cause_d;
  logic               faddr_en;

  assign faddr_en = fault_en | sw_we;

  always_comb begin
    faddr_d = faddr_q;
    fpc_d   = fpc_q;
    cause_d = cause_q;
    if (fault_en) begin
      faddr_d = fault_addr_in;
      fpc_d   = fault_pc_in;
      cause_d = CAUSE_PROT_SUPV;
    end else if (sw_we) begin
      faddr_d = sw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= '0;
    end else if (faddr_en) begin
      faddr_q <= faddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpc_q   <= '0;
      cause_q <= '0;
    end else if (fault_en) begin
      fpc_q   <= fpc_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/mmr_addr_guard.sv
module mmr_addr_guard
  import mmr_guard_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 9,
  parameter logic [NUM_PERIPH-1:0][11:0] OFF_LIMIT = {
    12'h104, 12'h200, 12'h100, 12'h00C, 12'h004,
    12'h00C, 12'h110, 12'h404, 12'h404
  }
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [31:0]        req_addr,
  input  logic               req_write,
  input  logic [31:0]        req_wdata,
  input  logic [31:0]        req_pc,
  output logic [31:0]        rsp_rdata,
  output logic               dn_valid,
  output logic [31:0]        dn_addr,
  output logic               dn_write,
  output logic [31:0]        dn_wdata,
  input  logic [31:0]        dn_rdata,
  output logic               exc_valid,
  output logic [5:0]         exc_cause,
  input  logic               sw_faddr_we,
  input  logic [31:0]        sw_faddr_data,
  output logic [31:0]        fault_addr,
  output logic [31:0]        fault_pc,
  output logic [5:0]         fault_cause
);
  logic in_window;
  logic map_legal;
  logic bad_req;

  mmr_window_decode #(
    .NUM_PERIPH (NUM_PERIPH),
    .OFF_LIMIT  (OFF_LIMIT)
  ) u_decode (
    .addr      (req_addr),
    .in_window (in_window),
    .legal     (map_legal)
  );

  assign bad_req   = req_valid && in_window && !map_legal;

  assign dn_valid  = req_valid && !bad_req;
  assign dn_addr   = req_addr;
  assign dn_write  = req_write;
  assign dn_wdata  = req_wdata;
  assign rsp_rdata = bad_req ? '0 : dn_rdata;
  assign exc_valid = bad_req;
  assign exc_cause = bad_req ? CAUSE_PROT_SUPV : CAUSE_NONE;

  mmr_fault_capture u_capture (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault_en      (bad_req),
    .fault_addr_in (req_addr),
    .fault_pc_in   (req_pc),
    .sw_we         (sw_faddr_we),
    .sw_data       (sw_faddr_data),
    .faddr_q       (fault_addr),
    .fpc_q         (fault_pc),
    .cause_q       (fault_cause)
  );
endmodule

// File: rtl/mmr_addr_guard_chk.sv
module mmr_addr_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_write,
  input logic [31:0] req_pc,
  input logic [31:0] rsp_rdata,
  input logic        dn_valid,
  input logic [31:0] dn_addr,
  input logic        exc_valid,
  input logic [5:0]  exc_cause,
  input logic        sw_faddr_we,
  input logic [31:0] fault_addr,
  input logic [31:0] fault_pc,
  input logic [5:0]  fault_cause
);
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[31:20] != 12'hFFE) |-> !exc_valid);

  a_r2_high_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:20] == 12'hFFE && req_addr[19:16] != 4'h0) |-> exc_valid);

  a_r6_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!dn_valid && exc_cause == 6'h2E));

  a_r6_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !exc_valid);

  a_r7_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !req_write) |-> rsp_rdata == 32'h0);

  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (fault_addr == $past(req_addr) && fault_pc == $past(req_pc)
                   && fault_cause == 6'h2E));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !sw_faddr_we) |=> ($stable(fault_addr) && $stable(fault_pc)
                                      && $stable(fault_cause)));

  a_r11_pass: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_addr == req_addr && req_valid));
endmodule

bind mmr_addr_guard mmr_addr_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_write   (req_write),
  .req_pc      (req_pc),
  .rsp_rdata   (rsp_rdata),
  .dn_valid    (dn_valid),
  .dn_addr     (dn_addr),
  .exc_valid   (exc_valid),
  .exc_cause   (exc_cause),
  .sw_faddr_we (sw_faddr_we),
  .fault_addr  (fault_addr),
  .fault_pc    (fault_pc),
  .fault_cause (fault_cause)
);

// File: tb/tb_mmr_addr_guard.sv
module tb_mmr_addr_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;
  localparam logic [31:0] RD_MARK = 32'hA5A5_A5A5;

  // {address, expect_fault, requirement number}
  localparam logic [36:0] VEC [NVEC] = '{
    {32'hFFE8_0000, 1'b1, 4'd2},  // R2
    {32'hFFE4_0000, 1'b1, 4'd2},
    {32'hFFE2_0000, 1'b1, 4'd2},
    {32'hFFE1_0000, 1'b1, 4'd2},
    {32'hFFE0_9000, 1'b1, 4'd3},  // R3
    {32'hFFE0_F000, 1'b1, 4'd3},
    {32'hFFE0_0408, 1'b1, 4'd4},  // R4 over limit
    {32'hFFE0_1408, 1'b1, 4'd4},
    {32'hFFE0_2114, 1'b1, 4'd4},
    {32'hFFE0_3010, 1'b1, 4'd4},
    {32'hFFE0_4008, 1'b1, 4'd4},
    {32'hFFE0_5010, 1'b1, 4'd4},
    {32'hFFE0_6104, 1'b1, 4'd4},
    {32'hFFE0_7204, 1'b1, 4'd4},
    {32'hFFE0_8108, 1'b1, 4'd4},
    {32'hFFE0_0404, 1'b0, 4'd4},  // R4 at limit
    {32'hFFE0_2110, 1'b0, 4'd4},
    {32'hFFE0_300C, 1'b0, 4'd4},
    {32'hFFE0_4004, 1'b0, 4'd4},
    {32'hFFE0_8104, 1'b0, 4'd4},
    {32'hFFE0_0002, 1'b1, 4'd5},  // R5
    {32'hFFE0_6001, 1'b1, 4'd5},
    {32'hFFC0_0000, 1'b0, 4'd1},  // R1
    {32'hFFF0_0000, 1'b0, 4'd1},
    {32'h0000_0003, 1'b0, 4'd1}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic [31:0] req_wdata;
  logic [31:0] req_pc;
  logic [31:0] rsp_rdata;
  logic        dn_valid;
  logic [31:0] dn_addr;
  logic        dn_write;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;
  logic        exc_valid;
  logic [5:0]  exc_cause;
  logic        sw_faddr_we;
  logic [31:0] sw_faddr_data;
  logic [31:0] fault_addr;
  logic [31:0] fault_pc;
  logic [5:0]  fault_cause;

  int checks;
  int errors;

  mmr_addr_guard dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_pc(req_pc),
    .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_addr(dn_addr),
    .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .sw_faddr_we(sw_faddr_we),
    .sw_faddr_data(sw_faddr_data), .fault_addr(fault_addr),
    .fault_pc(fault_pc), .fault_cause(fault_cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] a, input logic w,
                       input logic [31:0] pc);
    @(negedge clk);
    req_valid = v;
    req_addr  = a;
    req_write = w;
    req_wdata = 32'hDEAD_BEEF;
    req_pc    = pc;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_wdata = '0; req_pc = '0; dn_rdata = RD_MARK;
    sw_faddr_we = 1'b0; sw_faddr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 fault_addr", fault_addr, 32'h0);
    chk("R10 fault_pc", fault_pc, 32'h0);
    chk("R10 fault_cause", {26'h0, fault_cause}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] a;
      logic        bad;
      string       t;
      a   = VEC[i][36:5];
      bad = VEC[i][4];
      t   = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      drive(1'b1, a, 1'b1, 32'h0000_1000 + 32'(i) * 4);
      chk({t, " exc"}, {31'h0, exc_valid}, {31'h0, bad});
      chk({t, " dn_valid"}, {31'h0, dn_valid}, {31'h0, !bad});
      if (bad) begin
        chk({t, " R6 cause"}, {26'h0, exc_cause}, 32'h2E);
        after_edge();
        chk({t, " R8 faddr"}, fault_addr, a);
        chk({t, " R8 fpc"}, fault_pc, 32'h0000_1000 + 32'(i) * 4);
      end else begin
        chk({t, " R11 dn_addr"}, dn_addr, a);
        chk({t, " R11 dn_wdata"}, dn_wdata, 32'hDEAD_BEEF);
        chk({t, " R11 dn_write"}, {31'h0, dn_write}, 32'h1);
      end
    end

    // R7: illegal read returns zero, legal read returns downstream data
    drive(1'b1, 32'hFFE0_5010, 1'b0, 32'h0000_2000);
    chk("R7 bad read", rsp_rdata, 32'h0);
    drive(1'b1, 32'hFFE0_5008, 1'b0, 32'h0000_2004);
    chk("R7 good read", rsp_rdata, RD_MARK);
    after_edge();
    // R8: legal access leaves captured state alone
    chk("R8 hold addr", fault_addr, 32'hFFE0_5010);
    chk("R8 hold pc", fault_pc, 32'h0000_2000);
    chk("R8 cause", {26'h0, fault_cause}, 32'h2E);

    // R6: invalid request with illegal address does nothing
    drive(1'b0, 32'hFFE8_0000, 1'b1, 32'h0000_3000);
    chk("R6 idle exc", {31'h0, exc_valid}, 32'h0);
    after_edge();
    chk("R6 idle faddr", fault_addr, 32'hFFE0_5010);

    // R9: software clear, then collision with a fault
    @(negedge clk);
    req_valid = 1'b0; sw_faddr_we = 1'b1; sw_faddr_data = 32'h0;
    after_edge();
    chk("R9 sw write", fault_addr, 32'h0);
    @(negedge clk);
    sw_faddr_data = 32'h1234_5678;
    req_valid = 1'b1; req_addr = 32'hFFE0_9000; req_write = 1'b1;
    req_pc = 32'h0000_4000;
    after_edge();
    chk("R9 fault wins", fault_addr, 32'hFFE0_9000);
    chk("R9 fault pc", fault_pc, 32'h0000_4000);
    @(negedge clk);
    sw_faddr_we = 1'b0; req_valid = 1'b0;
    after_edge();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule